// File: doc/BRIEF.md
# Lane PHY power-up sequencer

This block brings one lane of a four-lane serial PHY out of reset and confirms that the PHY PLL is stable. A one-cycle start pulse with a lane index begins a run. The block first takes the PHY out of reset. It then places the PLL-lock test address on the test-register writer port and releases transmit electrical idle for the chosen lane. After that it checks the PLL status three times.

The first check waits for PLL lock. Two test-register writes then reconfigure the clocking. The second check waits for the PLL-output status to clear. The block then puts the lock address back on the port, and the third check waits for lock again. Each check samples its status flag a bounded number of times, with a fixed wait between samples. The wait is counted in prescaled ticks so that a simulation can use a short interval. Each check that runs out of samples has its own error code.

When a run ends, the block pulses `done_o` and returns the result on `err_o`. A lane that completes without error is added to a mask of powered lanes.

Top module: `lane_phy_pwrup_seq`

## Requirements
- R1: Reset state:
  - `phy_rst_o` is 1.
  - Every `tx_idle_o` bit is 1 (bit n is 1 while lane n is idle).
  - `busy_o`, `done_o`, `treg_wr_o`, `err_o` and `lane_mask_o` are all 0.
- R2: A start pulse while idle raises `busy_o` on the next cycle. `phy_rst_o` then falls, and it never rises again until reset.
- R3: A run clears only the `tx_idle_o` bit of its own lane. No `tx_idle_o` bit ever returns to 1.
- R4: The first check requires `pll_lock_i` = 1. If all MAX_TRIES samples miss it, the run ends with `err_o` = 1 and makes no test-register write.
- R5: Once lock is seen, the block makes exactly two single-cycle writes, in this order:
  - first address 0x10 with data 0x8;
  - then address 0x12 with data 0x8.

  `treg_wr_o` is high only while `busy_o` is high.
- R6: The second check requires `pll_out_i` = 0. If all samples miss it, the run ends with `err_o` = 2.
- R7: The block then drives address 0x10 on `treg_addr_o` and checks again for `pll_lock_i` = 1. If all samples miss it, the run ends with `err_o` = 3. After any run that reaches the lock check, `treg_addr_o` reads 0x10.
- R8: A run that passes all three checks ends with `err_o` = 0 and sets bit n of `lane_mask_o` for lane n. Bits set by earlier runs are kept.
- R9: A run that fails leaves `lane_mask_o` unchanged. The mask changes only in the cycle in which a successful `done_o` is shown.
- R10: A start pulse while `busy_o` is high is ignored. The lane of the run already in progress is kept.
- R11: The wait between two samples lasts at least TICK_DIV*POLL_TICKS cycles. A check therefore cannot fail sooner than (MAX_TRIES-1) such waits after it begins.
- R12: `done_o` is a one-cycle pulse in the same cycle in which `busy_o` falls. `err_o` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| lane_i | input | LANE_W | Lane to power up |
| pll_lock_i | input | 1 | PLL locked status |
| pll_out_i | input | 1 | PLL output status; the second check waits for it to read 0 |
| phy_rst_o | output | 1 | PHY reset, active high |
| tx_idle_o | output | LANES | Transmit electrical idle, one bit per lane |
| treg_addr_o | output | 6 | Test-register address |
| treg_data_o | output | 4 | Test-register write data |
| treg_wr_o | output | 1 | Test-register write strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Run finished pulse |
| err_o | output | 2 | Result: 0 ok, 1 lock, 2 output, 3 relock |
| lane_mask_o | output | LANES | Lanes powered successfully |

## Verification
A status PHY model in the bench delays or withholds each of the three status conditions independently. In each failure run only one check misses, so a design that mixes up the phase-to-code mapping reports the wrong error. A design that polls the output flag for the wrong polarity also reports the wrong error.

A sixth sample, or a wait that is too short, would move the moment of failure outside the window that the bench computes from the tick parameters. The bench also counts and orders the test-register writes: a swapped order, or writes issued before lock, shows up directly.

A start pulse injected mid-run would restart the run on a new lane if it were not ignored, and the wrong mask bit would then be set. Failed runs on fresh lanes would leave mask bits behind if the mask were updated on every completion.

// File: rtl/lps_pkg.sv
package lps_pkg;

   localparam int TREG_AW = 6;
   localparam int TREG_DW = 4;

   // Test-register addresses and data used by the sequence
   localparam logic [TREG_AW-1:0] TA_PLL_CHK  = 6'h10;
   localparam logic [TREG_AW-1:0] TA_CLK_SCC  = 6'h12;
   localparam logic [TREG_DW-1:0] TD_SEP_RATE = 4'h8;
   localparam logic [TREG_DW-1:0] TD_PLL_100M = 4'h8;

   typedef enum logic [1:0] {
      ERR_NONE   = 2'd0,
      ERR_LOCK   = 2'd1,
      ERR_OUTPUT = 2'd2,
      ERR_RELOCK = 2'd3
   } err_e;

   typedef enum logic [1:0] {
      PH_LOCK   = 2'd0,
      PH_OUTPUT = 2'd1,
      PH_RELOCK = 2'd2
   } phase_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RELEASE,
      ST_POINT,
      ST_TXON,
      ST_POLL,
      ST_WAIT,
      ST_WR1,
      ST_GAP1,
      ST_WR2,
      ST_GAP2,
      ST_REPOINT
   } state_e;

   function automatic err_e phase_err(phase_e p);
      case (p)
         PH_LOCK:   phase_err = ERR_LOCK;
         PH_OUTPUT: phase_err = ERR_OUTPUT;
         default:   phase_err = ERR_RELOCK;
      endcase
   endfunction

endpackage

// File: rtl/lps_tick_gen.sv
module lps_tick_gen #(
   parameter int TICK_DIV = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("lps_tick_gen: TICK_DIV must be at least 1");
      end

      if (TICK_DIV == 1) begin : g_passthru
         // Every cycle is a tick; a clear only masks the current one
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign tick_o    = !clr_i;
      end else begin : g_counter
         localparam int CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr_i) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick_o = (cnt_q == LAST) && !clr_i;
      end
   endgenerate

endmodule

// File: rtl/lps_interval_timer.sv
module lps_interval_timer #(
   parameter int POLL_TICKS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic tick_i,
   output logic expire_o
);

   generate
      if (POLL_TICKS < 1) begin : g_bad_ticks
         $error("lps_interval_timer: POLL_TICKS must be at least 1");
      end
   endgenerate

   localparam int CW = $clog2(POLL_TICKS + 1);
   localparam logic [CW-1:0] FULL = CW'(POLL_TICKS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != FULL)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire_o = (cnt_q == FULL);

endmodule

// File: rtl/lps_retry_ctr.sv
module lps_retry_ctr #(
   parameter int MAX_TRIES = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("lps_retry_ctr: MAX_TRIES must be at least 1");
      end
   endgenerate

   localparam int TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
   localparam logic [TW-1:0] LAST = TW'(MAX_TRIES - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && (cnt_q != LAST)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last_o = (cnt_q == LAST);

endmodule

// File: rtl/lps_lane_mask.sv
module lps_lane_mask #(
   parameter int LANES  = 4,
   parameter int LANE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic [LANE_W-1:0] idx_i,
   output logic [LANES-1:0]  mask_o
);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_bit
         logic bit_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else if (set_i && (idx_i == LANE_W'(g))) begin
               bit_q <= 1'b1;
            end
         end

         assign mask_o[g] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/lane_phy_pwrup_seq.sv
module lane_phy_pwrup_seq
   import lps_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int TICK_DIV   = 125000,
   parameter int POLL_TICKS = 20,
   parameter int MAX_TRIES  = 50,
   parameter int LANE_W     = $clog2(LANES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [LANE_W-1:0]      lane_i,
   input  logic                   pll_lock_i,
   input  logic                   pll_out_i,
   output logic                   phy_rst_o,
   output logic [LANES-1:0]       tx_idle_o,
   output logic [TREG_AW-1:0]     treg_addr_o,
   output logic [TREG_DW-1:0]     treg_data_o,
   output logic                   treg_wr_o,
   output logic                   busy_o,
   output logic                   done_o,
   output logic [1:0]             err_o,
   output logic [LANES-1:0]       lane_mask_o
);

   generate
      if (LANES < 2 || LANES != (1 << LANE_W)) begin : g_bad_lanes
         $error("lane_phy_pwrup_seq: LANES must be a power of two, at least 2");
      end
   endgenerate

   state_e            state_q;
   phase_e            phase_q;
   err_e              err_q;
   logic [LANE_W-1:0] lane_q;
   logic              phy_rst_q;
   logic [LANES-1:0]  tx_idle_q;
   logic [TREG_AW-1:0] taddr_q;
   logic [TREG_DW-1:0] tdata_q;
   logic              twr_q;
   logic              busy_q;
   logic              done_q;

   logic poll_ok;
   logic tries_last;
   logic wait_start;
   logic tries_clr;
   logic tick;
   logic interval_done;
   logic mask_set;

   // Condition looked for in the current phase
   assign poll_ok    = (phase_q == PH_OUTPUT) ? !pll_out_i : pll_lock_i;
   assign wait_start = (state_q == ST_POLL) && !poll_ok && !tries_last;
   assign tries_clr  = (state_q == ST_TXON) || (state_q == ST_GAP2) ||
                       (state_q == ST_REPOINT);
   assign mask_set   = (state_q == ST_POLL) && poll_ok && (phase_q == PH_RELOCK);

   lps_tick_gen #(
      .TICK_DIV (TICK_DIV)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (wait_start),
      .tick_o (tick)
   );

   lps_interval_timer #(
      .POLL_TICKS (POLL_TICKS)
   ) u_interval (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (wait_start),
      .tick_i   (tick),
      .expire_o (interval_done)
   );

   lps_retry_ctr #(
      .MAX_TRIES (MAX_TRIES)
   ) u_tries (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (tries_clr),
      .inc_i  (wait_start),
      .last_o (tries_last)
   );

   lps_lane_mask #(
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (mask_set),
      .idx_i  (lane_q),
      .mask_o (lane_mask_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         phase_q   <= PH_LOCK;
         err_q     <= ERR_NONE;
         lane_q    <= '0;
         phy_rst_q <= 1'b1;
         tx_idle_q <= '1;
         taddr_q   <= '0;
         tdata_q   <= '0;
         twr_q     <= 1'b0;
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         twr_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  lane_q  <= lane_i;
                  busy_q  <= 1'b1;
                  err_q   <= ERR_NONE;
                  state_q <= ST_RELEASE;
               end
            end
            ST_RELEASE: begin
               phy_rst_q <= 1'b0;
               state_q   <= ST_POINT;
            end
            ST_POINT: begin
               taddr_q <= TA_PLL_CHK;
               state_q <= ST_TXON;
            end
            ST_TXON: begin
               tx_idle_q[lane_q] <= 1'b0;
               phase_q           <= PH_LOCK;
               state_q           <= ST_POLL;
            end
            ST_POLL: begin
               if (poll_ok) begin
                  case (phase_q)
                     PH_LOCK:   state_q <= ST_WR1;
                     PH_OUTPUT: state_q <= ST_REPOINT;
                     default: begin
                        busy_q  <= 1'b0;
                        done_q  <= 1'b1;
                        err_q   <= ERR_NONE;
                        state_q <= ST_IDLE;
                     end
                  endcase
               end else if (tries_last) begin
                  busy_q  <= 1'b0;
                  done_q  <= 1'b1;
                  err_q   <= phase_err(phase_q);
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (interval_done) begin
                  state_q <= ST_POLL;
               end
            end
            ST_WR1: begin
               taddr_q <= TA_PLL_CHK;
               tdata_q <= TD_SEP_RATE;
               twr_q   <= 1'b1;
               state_q <= ST_GAP1;
            end
            ST_GAP1: begin
               state_q <= ST_WR2;
            end
            ST_WR2: begin
               taddr_q <= TA_CLK_SCC;
               tdata_q <= TD_PLL_100M;
               twr_q   <= 1'b1;
               state_q <= ST_GAP2;
            end
            ST_GAP2: begin
               phase_q <= PH_OUTPUT;
               state_q <= ST_POLL;
            end
            ST_REPOINT: begin
               taddr_q <= TA_PLL_CHK;
               phase_q <= PH_RELOCK;
               state_q <= ST_POLL;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign phy_rst_o   = phy_rst_q;
   assign tx_idle_o   = tx_idle_q;
   assign treg_addr_o = taddr_q;
   assign treg_data_o = tdata_q;
   assign treg_wr_o   = twr_q;
   assign busy_o      = busy_q;
   assign done_o      = done_q;
   assign err_o       = err_q;

endmodule

// File: rtl/lps_seq_checker.sv
module lps_seq_checker #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             phy_rst_o,
   input logic [LANES-1:0] tx_idle_o,
   input logic             treg_wr_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [1:0]       err_o,
   input logic [LANES-1:0] lane_mask_o
);

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o); // R2

   AST_RST_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !phy_rst_o |=> !phy_rst_o); // R2

   AST_IDLE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones($past(tx_idle_o) & ~tx_idle_o) <= 1)); // R3

   AST_IDLE_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((tx_idle_o & ~$past(tx_idle_o)) == '0)); // R3

   AST_WR_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      treg_wr_o |-> busy_o); // R5

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      treg_wr_o |=> !treg_wr_o); // R5

   AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lane_mask_o & $past(lane_mask_o)) == $past(lane_mask_o))); // R8

   AST_MASK_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lane_mask_o == $past(lane_mask_o)) || (done_o && err_o == 2'd0))); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R12

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o))); // R12

   AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(err_o)); // R12

endmodule

bind lane_phy_pwrup_seq lps_seq_checker #(
   .LANES (LANES)
) u_lps_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .phy_rst_o   (phy_rst_o),
   .tx_idle_o   (tx_idle_o),
   .treg_wr_o   (treg_wr_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .err_o       (err_o),
   .lane_mask_o (lane_mask_o)
);

// File: tb/lane_phy_pwrup_seq_tb_top.sv
module lane_phy_pwrup_seq_tb_top;

   localparam int TDIV  = 2;
   localparam int PTICK = 3;
   localparam int TRIES = 5;
   localparam int WAITC = TDIV * PTICK;
   localparam int NEVER = 1000000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [1:0] lane_i = '0;
   logic       pll_lock_i = 1'b0;
   logic       pll_out_i = 1'b1;
   logic       phy_rst_o;
   logic [3:0] tx_idle_o;
   logic [5:0] treg_addr_o;
   logic [3:0] treg_data_o;
   logic       treg_wr_o;
   logic       busy_o;
   logic       done_o;
   logic [1:0] err_o;
   logic [3:0] lane_mask_o;

   int tests = 0;
   int fails = 0;

   // PHY status model state
   int         cyc = 0;
   int         wr_cyc = -1;
   int         lock_at = NEVER;
   int         out_at = NEVER;
   int         relock_at = NEVER;
   bit         model_clr = 1'b0;
   int         nwr = 0;
   logic [5:0] wa [0:7];
   logic [3:0] wd [0:7];

   always #4 clk = ~clk;

   lane_phy_pwrup_seq #(
      .LANES      (4),
      .TICK_DIV   (TDIV),
      .POLL_TICKS (PTICK),
      .MAX_TRIES  (TRIES)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .lane_i      (lane_i),
      .pll_lock_i  (pll_lock_i),
      .pll_out_i   (pll_out_i),
      .phy_rst_o   (phy_rst_o),
      .tx_idle_o   (tx_idle_o),
      .treg_addr_o (treg_addr_o),
      .treg_data_o (treg_data_o),
      .treg_wr_o   (treg_wr_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .err_o       (err_o),
      .lane_mask_o (lane_mask_o)
   );

   // Status model: lock after lock_at cycles, drops at the 0x12 write,
   // output flag clears out_at cycles later, lock returns relock_at later
   always @(negedge clk) begin
      if (model_clr) begin
         cyc       = 0;
         wr_cyc    = -1;
         nwr       = 0;
         model_clr = 1'b0;
      end else begin
         cyc++;
      end
      if (treg_wr_o) begin
         if (nwr < 8) begin
            wa[nwr] = treg_addr_o;
            wd[nwr] = treg_data_o;
         end
         nwr++;
         if (treg_addr_o == 6'h12 && wr_cyc < 0) wr_cyc = cyc;
      end
      if (wr_cyc < 0) begin
         pll_lock_i = (cyc >= lock_at);
         pll_out_i  = 1'b1;
      end else begin
         pll_lock_i = ((cyc - wr_cyc) >= relock_at);
         pll_out_i  = !((cyc - wr_cyc) >= out_at);
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Runs one sequence; returns cycles from start to done
   task automatic run_seq(input logic [1:0] lane, input int l_at, input int o_at,
                          input int r_at, input int inj_at, input logic [1:0] inj_lane,
                          output int ncyc);
      int n;
      @(posedge clk); #1;
      lock_at   = l_at;
      out_at    = o_at;
      relock_at = r_at;
      model_clr = 1'b1;
      lane_i    = lane;
      start_i   = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      n = 1;
      chk(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
      while (!done_o && n < 3000) begin
         @(posedge clk); #1;
         n++;
         if (n == inj_at) begin
            lane_i  = inj_lane;
            start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
      end
      start_i = 1'b0;
      chk(done_o == 1'b1, "R12", "done seen", int'(done_o), 1);
      chk(busy_o == 1'b0, "R12", "busy low at done", int'(busy_o), 0);
      chk(phy_rst_o == 1'b0, "R2", "phy reset released", int'(phy_rst_o), 0);
      ncyc = n;
   endtask

   task automatic after_done(input int exp_err);
      @(posedge clk); #1;
      chk(done_o == 1'b0, "R12", "done one cycle", int'(done_o), 0);
      repeat (3) @(posedge clk);
      #1;
      chk(int'(err_o) == exp_err, "R12", "err held while idle", int'(err_o), exp_err);
   endtask

   task automatic t_reset;
      chk(phy_rst_o == 1'b1, "R1", "phy_rst", int'(phy_rst_o), 1);
      chk(tx_idle_o == 4'hF, "R1", "tx_idle", int'(tx_idle_o), 15);
      chk(busy_o == 1'b0, "R1", "busy", int'(busy_o), 0);
      chk(done_o == 1'b0, "R1", "done", int'(done_o), 0);
      chk(treg_wr_o == 1'b0, "R1", "treg_wr", int'(treg_wr_o), 0);
      chk(err_o == 2'd0, "R1", "err", int'(err_o), 0);
      chk(lane_mask_o == 4'h0, "R1", "mask", int'(lane_mask_o), 0);
   endtask

   task automatic t_success_lane2;
      int n;
      run_seq(2'd2, 10, 8, 30, 0, 2'd0, n);
      chk(err_o == 2'd0, "R8", "err ok", int'(err_o), 0);
      chk(lane_mask_o == 4'b0100, "R8", "mask", int'(lane_mask_o), 4);
      chk(tx_idle_o == 4'b1011, "R3", "tx_idle", int'(tx_idle_o), 11);
      chk(nwr == 2, "R5", "write count", nwr, 2);
      chk(wa[0] == 6'h10 && wd[0] == 4'h8, "R5", "first write addr",
          int'(wa[0]), 16);
      chk(wa[1] == 6'h12 && wd[1] == 4'h8, "R5", "second write addr",
          int'(wa[1]), 18);
      chk(treg_addr_o == 6'h10, "R7", "address pointed back", int'(treg_addr_o), 16);
      after_done(0);
   endtask

   task automatic t_lock_fail_lane1;
      int n;
      int lo;
      int hi;
      run_seq(2'd1, NEVER, 0, 0, 0, 2'd0, n);
      lo = (TRIES - 1) * WAITC;
      hi = (TRIES - 1) * (WAITC + 3) + TRIES + 8;
      chk(err_o == 2'd1, "R4", "lock timeout code", int'(err_o), 1);
      chk(nwr == 0, "R4", "no writes", nwr, 0);
      chk(lane_mask_o == 4'b0100, "R9", "mask unchanged", int'(lane_mask_o), 4);
      chk(tx_idle_o == 4'b1001, "R3", "tx_idle", int'(tx_idle_o), 9);
      chk(treg_addr_o == 6'h10, "R7", "address at lock check", int'(treg_addr_o), 16);
      chk(n >= lo, "R11", "timeout not early", n, lo);
      chk(n <= hi, "R11", "timeout not late", n, hi);
      after_done(1);
   endtask

   task automatic t_output_fail_lane3;
      int n;
      run_seq(2'd3, 0, NEVER, 0, 0, 2'd0, n);
      chk(err_o == 2'd2, "R6", "output timeout code", int'(err_o), 2);
      chk(nwr == 2, "R6", "writes before output check", nwr, 2);
      chk(lane_mask_o == 4'b0100, "R9", "mask unchanged", int'(lane_mask_o), 4);
      after_done(2);
   endtask

   task automatic t_relock_fail_lane0;
      int n;
      run_seq(2'd0, 0, 4, NEVER, 0, 2'd0, n);
      chk(err_o == 2'd3, "R7", "relock timeout code", int'(err_o), 3);
      chk(lane_mask_o == 4'b0100, "R9", "mask unchanged", int'(lane_mask_o), 4);
      chk(treg_addr_o == 6'h10, "R7", "address pointed back", int'(treg_addr_o), 16);
      after_done(3);
   endtask

   task automatic t_quick_lane0;
      int n;
      run_seq(2'd0, 0, 0, 0, 0, 2'd0, n);
      chk(err_o == 2'd0, "R8", "err ok", int'(err_o), 0);
      chk(lane_mask_o == 4'b0101, "R8", "mask accumulates", int'(lane_mask_o), 5);
      after_done(0);
   endtask

   task automatic t_late_lock_lane3;
      int n;
      // Lock arrives before the last sample: must still succeed (R4)
      run_seq(2'd3, (TRIES - 2) * WAITC, 0, 0, 6, 2'd1, n);
      chk(err_o == 2'd0, "R4", "late lock accepted", int'(err_o), 0);
      chk(lane_mask_o == 4'b1101, "R10", "mid-run start ignored",
          int'(lane_mask_o), 13);
      chk(nwr == 2, "R10", "no restart", nwr, 2);
      after_done(0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      t_reset();
      t_success_lane2();
      t_lock_fail_lane1();
      t_output_fail_lane3();
      t_relock_fail_lane0();
      t_quick_lane0();
      t_late_lock_lane3();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule